// File: doc/BRIEF.md
# SDRAM Mode Register Capture Unit

This block sits on the device side of a DDR SDRAM command bus and watches for register-write commands. When one arrives, it latches the address bus into either the base mode register or the extended mode register, according to bank-address bit 0. It then presents the decoded operating settings as plain outputs. The memory array, refresh engine, DLL and output drivers that consume those settings are outside it.

A write is taken only when the clock enable has been high for two consecutive edges and all banks report idle. Otherwise the write is rejected and flagged. Each accepted write opens a busy window of two cycles, and any write command seen during that window is dropped. Writes that set the test bit, or that set reserved extended bits, are still latched but raise an illegal-write pulse. Burst-length and CAS-latency codes that this device does not support raise a level flag. Neither register has a defined power-up value, so each one carries a valid flag.

Top module: `sdram_mode_capture`

## Requirements
- R1: A register-write command is one clock edge at which cs_n, ras_n, cas_n and we_n are all low. Any other strobe combination changes no register, no flag and no busy state.
- R2: With ba[0]=0 a write targets the base register. With ba[0]=1 it targets the extended register. The register that is not selected keeps its contents.
- R3: A write is accepted only if cke was high at this edge and at the previous edge, and banks_idle is high. Otherwise err_reject is high for the one cycle after the edge, and neither register changes. The first edge after reset always counts as having cke low before it.
- R4: After an accepted write, busy is high for exactly 2 cycles. A write command presented while busy is high is ignored: it raises no flag and changes no state.
- R5: Base register fields: burst_code=addr[2:0], burst_interleave=addr[3] (1 means interleaved), cas_code=addr[6:4].
- R6: burst_beats is 2, 4 or 8 for burst_code 1, 2 or 3, and 0 otherwise. cas_cycles is 2 or 3 for cas_code 2 or 3, and 0 otherwise. unsupported is high when base_valid is high and either decode is 0.
- R7: addr[7] of a base write is latched as test_mode. When it is set, err_illegal pulses for one cycle.
- R8: addr[8] of an accepted base write produces a one-cycle dll_reset_pulse. It is not stored.
- R9: Extended fields: dll_enable=~addr[0], sr_extent=addr[3:1], drive_strength=addr[6:5], sr_temp=addr[8:7].
- R10: An accepted extended write with addr[4], any of addr[ADDR_W-1:9], or ba[1] set pulses err_illegal for one cycle. Its defined fields are still latched.
- R11: base_valid and ext_valid are low from reset until their register is first written, and they stay high after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address; bit 0 selects the register |
| addr | input | ADDR_W | Address bus carrying register contents |
| banks_idle | input | 1 | All banks precharged and idle |
| busy | output | 1 | Completion window after a write |
| base_valid | output | 1 | Base register has been written |
| ext_valid | output | 1 | Extended register has been written |
| burst_code | output | 3 | Raw burst-length code |
| burst_interleave | output | 1 | Interleaved burst ordering |
| burst_beats | output | 4 | Decoded burst length, 0 if unsupported |
| cas_code | output | 3 | Raw CAS-latency code |
| cas_cycles | output | 2 | Decoded CAS latency, 0 if unsupported |
| test_mode | output | 1 | Test bit as written |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| dll_enable | output | 1 | DLL enabled |
| drive_strength | output | 2 | Output driver strength select |
| sr_temp | output | 2 | Temperature-compensated self-refresh setting |
| sr_extent | output | 3 | Partial-array self-refresh extent |
| unsupported | output | 1 | Base register holds an unsupported code |
| err_reject | output | 1 | One-cycle pulse: write refused by preconditions |
| err_illegal | output | 1 | One-cycle pulse: test or reserved bits set |

## Verification
The bench builds the block with ADDR_W=13 and BUSY_CYCLES=2, which are the defaults. With 13 address bits, the reserved extended bits 12:9 exist and can be set by random addresses. A busy window of two cycles lets random back-to-back write commands land both inside and just past the window. The random mix of cke drops and idle status exercises the reject path, including the case where cke rose only at the previous edge.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

  localparam int DLL_RST_BIT = 8;
  localparam int TEST_BIT    = 7;
  localparam int EXT_RSV_BIT = 4;
  localparam int EXT_TOP_DEF = 8;

  typedef struct packed {
    logic [2:0] bl_code;
    logic       interleave;
    logic [2:0] cl_code;
    logic       test;
  } base_fields_t;

  typedef struct packed {
    logic       dll_off;
    logic [2:0] extent;
    logic [1:0] drive;
    logic [1:0] temp;
  } ext_fields_t;

  function automatic logic [3:0] bl_beats(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [1:0] cl_cycles(input logic [2:0] code);
    case (code)
      3'd2:    return 2'd2;
      3'd3:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/smc_cmd_decode.sv
module smc_cmd_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic banks_idle,
  input  logic bank_sel,
  input  logic busy,
  output logic wr_cmd,
  output logic accept_base,
  output logic accept_ext,
  output logic reject_pulse
);
  logic cke_q;
  logic take;
  logic ready;

  assign wr_cmd      = ~(cs_n | ras_n | cas_n | we_n);
  assign take        = wr_cmd & ~busy;
  assign ready       = cke & cke_q & banks_idle;
  assign accept_base = take & ready & ~bank_sel;
  assign accept_ext  = take & ready & bank_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q        <= 1'b0;
      reject_pulse <= 1'b0;
    end else begin
      cke_q        <= cke;
      reject_pulse <= take & ~ready;
    end
  end
endmodule

// File: rtl/smc_busy_timer.sv
module smc_busy_timer #(
  parameter int CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= CW'(CYCLES);
    else if (busy)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/smc_base_reg.sv
module smc_base_reg
  import sdram_mode_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [8:0]   a,
  output base_fields_t fields,
  output logic         valid,
  output logic         dll_rst,
  output logic         illegal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields  <= '0;
      valid   <= 1'b0;
      dll_rst <= 1'b0;
      illegal <= 1'b0;
    end else begin
      dll_rst <= wr & a[DLL_RST_BIT];
      illegal <= wr & a[TEST_BIT];
      if (wr) begin
        fields.bl_code    <= a[2:0];
        fields.interleave <= a[3];
        fields.cl_code    <= a[6:4];
        fields.test       <= a[TEST_BIT];
        valid             <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smc_ext_reg.sv
module smc_ext_reg
  import sdram_mode_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] a,
  input  logic              ba_hi,
  output ext_fields_t       fields,
  output logic              valid,
  output logic              illegal
);
  logic rsv_set;

  generate
    if (ADDR_W > EXT_TOP_DEF + 1) begin : g_wide
      assign rsv_set = a[EXT_RSV_BIT] | ba_hi | (|a[ADDR_W-1:EXT_TOP_DEF+1]);
    end else begin : g_narrow
      assign rsv_set = a[EXT_RSV_BIT] | ba_hi;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields  <= '0;
      valid   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      illegal <= wr & rsv_set;
      if (wr) begin
        fields.dll_off <= a[0];
        fields.extent  <= a[3:1];
        fields.drive   <= a[6:5];
        fields.temp    <= a[8:7];
        valid          <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_mode_capture.sv
module sdram_mode_capture
  import sdram_mode_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BUSY_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  output logic              busy,
  output logic              base_valid,
  output logic              ext_valid,
  output logic [2:0]        burst_code,
  output logic              burst_interleave,
  output logic [3:0]        burst_beats,
  output logic [2:0]        cas_code,
  output logic [1:0]        cas_cycles,
  output logic              test_mode,
  output logic              dll_reset_pulse,
  output logic              dll_enable,
  output logic [1:0]        drive_strength,
  output logic [1:0]        sr_temp,
  output logic [2:0]        sr_extent,
  output logic              unsupported,
  output logic              err_reject,
  output logic              err_illegal
);
  logic         wr_cmd;
  logic         accept_base;
  logic         accept_ext;
  logic         accept_any;
  logic         base_ill;
  logic         ext_ill;
  base_fields_t base_f;
  ext_fields_t  ext_f;
  logic [7:0]   base_word;
  logic [7:0]   ext_word;

  assign accept_any = accept_base | accept_ext;

  smc_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .banks_idle(banks_idle), .bank_sel(ba[0]),
    .busy(busy), .wr_cmd(wr_cmd), .accept_base(accept_base),
    .accept_ext(accept_ext), .reject_pulse(err_reject)
  );

  smc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(accept_any), .busy(busy)
  );

  smc_base_reg u_base (
    .clk(clk), .rst_n(rst_n), .wr(accept_base), .a(addr[8:0]),
    .fields(base_f), .valid(base_valid), .dll_rst(dll_reset_pulse),
    .illegal(base_ill)
  );

  smc_ext_reg #(.ADDR_W(ADDR_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .wr(accept_ext), .a(addr), .ba_hi(ba[1]),
    .fields(ext_f), .valid(ext_valid), .illegal(ext_ill)
  );

  assign err_illegal      = base_ill | ext_ill;
  assign burst_code       = base_f.bl_code;
  assign burst_interleave = base_f.interleave;
  assign cas_code         = base_f.cl_code;
  assign test_mode        = base_f.test;
  assign burst_beats      = bl_beats(base_f.bl_code);
  assign cas_cycles       = cl_cycles(base_f.cl_code);
  assign unsupported      = base_valid &
                            ((burst_beats == 4'd0) | (cas_cycles == 2'd0));
  assign dll_enable       = ~ext_f.dll_off;
  assign drive_strength   = ext_f.drive;
  assign sr_temp          = ext_f.temp;
  assign sr_extent        = ext_f.extent;
  assign base_word        = base_f;
  assign ext_word         = ext_f;
endmodule

// File: rtl/sdram_mode_capture_chk.sv
module sdram_mode_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_cmd,
  input logic       accept_any,
  input logic       busy,
  input logic       err_reject,
  input logic       err_illegal,
  input logic       dll_reset_pulse,
  input logic       base_valid,
  input logic       ext_valid,
  input logic       unsupported,
  input logic [7:0] base_word,
  input logic [7:0] ext_word
);
  p_accept_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_any |=> busy);

  p_busy_drops_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd) |=> (!err_reject && !err_illegal && !dll_reset_pulse));

  p_reject_keeps_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_reject |-> ($stable(base_word) && $stable(ext_word)));

  p_reject_not_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_reject |-> !err_illegal);

  p_dll_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |=> !dll_reset_pulse);

  p_base_valid_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    base_valid |=> base_valid);

  p_ext_valid_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |=> ext_valid);

  p_unsup_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !base_valid |-> !unsupported);
endmodule

bind sdram_mode_capture sdram_mode_capture_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .accept_any(accept_any),
  .busy(busy), .err_reject(err_reject), .err_illegal(err_illegal),
  .dll_reset_pulse(dll_reset_pulse), .base_valid(base_valid),
  .ext_valid(ext_valid), .unsupported(unsupported),
  .base_word(base_word), .ext_word(ext_word)
);

// File: tb/test_sdram_mode_capture.sv
`timescale 1ns/1ps
module test_sdram_mode_capture;
  localparam int AW = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [AW-1:0] addr = '0;
  logic banks_idle = 1'b1;
  logic busy, base_valid, ext_valid, burst_interleave, test_mode;
  logic dll_reset_pulse, dll_enable, unsupported, err_reject, err_illegal;
  logic [2:0] burst_code, cas_code, sr_extent;
  logic [3:0] burst_beats;
  logic [1:0] cas_cycles, drive_strength, sr_temp;

  sdram_mode_capture #(.ADDR_W(AW), .BUSY_CYCLES(2)) i_sdram_mode_capture (.*);

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit m_cke_prev, m_bv, m_ev, m_int, m_test, m_dll_on;
  bit e_rej, e_ill, e_dllr;
  int m_busy;
  int m_bl, m_cl, m_ext_n, m_drv, m_tmp;

  function automatic int exp_beats(int code);
    return (code >= 1 && code <= 3) ? (1 << code) : 0;
  endfunction
  function automatic int exp_cas(int code);
    return (code == 2 || code == 3) ? code : 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4", "busy", busy, m_busy != 0);
    chk("R11", "base_valid", base_valid, m_bv);
    chk("R11", "ext_valid", ext_valid, m_ev);
    chk("R3", "err_reject", err_reject, e_rej);
    chk("R7/R10", "err_illegal", err_illegal, e_ill);
    chk("R8", "dll_reset_pulse", dll_reset_pulse, e_dllr);
    chk("R6", "unsupported", unsupported,
        m_bv && (exp_beats(m_bl) == 0 || exp_cas(m_cl) == 0));
    if (m_bv) begin
      chk("R5", "burst_code", burst_code, m_bl);
      chk("R5", "burst_interleave", burst_interleave, m_int);
      chk("R5", "cas_code", cas_code, m_cl);
      chk("R6", "burst_beats", burst_beats, exp_beats(m_bl));
      chk("R6", "cas_cycles", cas_cycles, exp_cas(m_cl));
      chk("R7", "test_mode", test_mode, m_test);
    end
    if (m_ev) begin
      chk("R9", "dll_enable", dll_enable, m_dll_on);
      chk("R9", "sr_extent", sr_extent, m_ext_n);
      chk("R9", "drive_strength", drive_strength, m_drv);
      chk("R9", "sr_temp", sr_temp, m_tmp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(bit k, bit cs, bit ras, bit cas, bit we,
                       logic [1:0] b, logic [AW-1:0] a, bit idle);
    bit wr, acc;
    cke = k; cs_n = cs; ras_n = ras; cas_n = cas; we_n = we;
    ba = b; addr = a; banks_idle = idle;
    @(posedge clk);
    wr = !cs && !ras && !cas && !we;
    e_rej = 0; e_ill = 0; e_dllr = 0; acc = 0;
    if (wr && m_busy == 0) begin
      if (k && m_cke_prev && idle) acc = 1;
      else e_rej = 1;
    end
    if (acc && !b[0]) begin
      m_bl = int'(a & 13'h7); m_int = a[3]; m_cl = int'((a >> 4) & 13'h7);
      m_test = a[7]; m_bv = 1; e_ill = a[7]; e_dllr = a[8];
    end
    if (acc && b[0]) begin
      m_dll_on = !a[0]; m_ext_n = int'((a >> 1) & 13'h7);
      m_drv = int'((a >> 5) & 13'h3); m_tmp = int'((a >> 7) & 13'h3);
      m_ev = 1; e_ill = ((a & ~13'h1EF) != 0) || b[1];
    end
    m_busy = acc ? 2 : (m_busy > 0 ? m_busy - 1 : 0);
    m_cke_prev = k;
    @(negedge clk);
    compare_all();
  endtask

  task automatic nop(); cycle(1, 1, 1, 1, 1, 2'b00, '0, 1); endtask
  task automatic mrs(bit sel, logic [AW-1:0] a);
    cycle(1, 0, 0, 0, 0, {1'b0, sel}, a, 1);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_cke_prev = 0; m_busy = 0; m_bv = 0; m_ev = 0;
    // reset state, R11
    chk("R11", "base_valid after reset", base_valid, 0);
    chk("R11", "ext_valid after reset", ext_valid, 0);
    chk("R4", "busy after reset", busy, 0);
    // R3: first edge after reset counts as cke low before it
    mrs(0, 13'h033);
    chk("R3", "first-edge reject", err_reject, 1);
    nop(); nop();
    // R5/R6: BL8 sequential CL3
    mrs(0, 13'h033);
    chk("R6", "burst_beats 8", burst_beats, 8);
    chk("R6", "cas_cycles 3", cas_cycles, 3);
    chk("R2", "ext untouched by base write", ext_valid, 0);
    // R4: extended write inside busy window is dropped
    mrs(1, 13'h0CA);
    chk("R4", "write ignored while busy", ext_valid, 0);
    nop();
    // R9 / R2: extended write
    mrs(1, 13'h0CA);
    chk("R9", "sr_extent 5", sr_extent, 5);
    chk("R2", "base kept on ext write", burst_code, 3);
    nop(); nop();
    // R1: activate-like and read-like strobes do nothing
    cycle(1, 0, 0, 1, 1, 2'b00, 13'h1FF, 1);
    cycle(1, 0, 1, 0, 1, 2'b01, 13'h1FF, 1);
    cycle(1, 1, 0, 0, 0, 2'b00, 13'h1FF, 1);
    chk("R1", "non-write leaves burst_code", burst_code, 3);
    // R3: cke low, then cke just risen, then banks busy
    cycle(0, 0, 0, 0, 0, 2'b00, 13'h022, 1);
    cycle(1, 0, 0, 0, 0, 2'b00, 13'h022, 1);
    chk("R3", "cke just risen reject", err_reject, 1);
    cycle(1, 0, 0, 0, 0, 2'b00, 13'h022, 0);
    chk("R3", "banks not idle reject", err_reject, 1);
    // R7: test bit
    mrs(0, 13'h0A2); nop(); nop();
    // R8: DLL reset pulse, BL4 interleaved CL3
    mrs(0, 13'h13A);
    chk("R8", "dll pulse", dll_reset_pulse, 1);
    nop();
    chk("R8", "dll pulse ends", dll_reset_pulse, 0);
    nop();
    // R6: unsupported codes
    mrs(0, 13'h045); nop(); nop();
    chk("R6", "unsupported set", unsupported, 1);
    // R10: reserved extended bits and ba[1]
    cycle(1, 0, 0, 0, 0, 2'b11, 13'h1010, 1);
    chk("R10", "reserved ext flagged", err_illegal, 1);
    nop(); nop();
    cycle(1, 0, 0, 0, 0, 2'b01, 13'h0181, 1);
    chk("R10", "clean ext not flagged", err_illegal, 0);
    nop(); nop();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      bit k, idle, cs, ras, cas, we;
      logic [AW-1:0] a;
      r = $urandom % 10;
      k = ($urandom % 12) != 0;
      idle = ($urandom % 8) != 0;
      if (r < 5) begin cs = 0; ras = 0; cas = 0; we = 0; end
      else if (r < 8) begin cs = $urandom; ras = $urandom; cas = $urandom; we = $urandom; end
      else begin cs = 1; ras = 1; cas = 1; we = 1; end
      a = AW'($urandom);
      if (($urandom % 4) != 0) a = a & 13'h1EF;
      if (($urandom % 3) != 0) a[7] = 1'b0;
      cycle(k, cs, ras, cas, we, 2'($urandom), a, idle);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule